// File: doc/BRIEF.md
# Segment Lookaside Buffer Unit

This block holds a small, fully associative table of segment entries. Each entry maps the upper bits of a 64-bit effective address to a 64-bit segment descriptor. Each entry matches either a 256 MB region or a 1 TB region, as chosen by a size field inside its descriptor. A lookup port compares an address against every entry in parallel. One cycle later it returns hit, slot and descriptor.

A single operation port carries the maintenance work: slot-indexed writes and reads, a find-by-address query, invalidation of the entry that matches an address, and invalidate-all. Invalidate-all takes a 3-bit hint that picks which entries are cleared. Invalidations also produce a one-cycle flush request for a downstream translation cache, marked local or global.

Operand layout. The address/slot operand `op_rb` carries the segment tag in [63:28], the valid bit in [27], reserved bits in [26:12] that must be zero, and the slot number in [11:0]. The descriptor `op_rs` carries the segment size in [63:62] (00 = 256 MB, 01 = 1 TB, 1x undefined), the class bit in [7] and the page-size code in [5:4].

The operation codes on `op_code` are:

| Code | Operation |
|---|---|
| 0 | write |
| 1 | read tag word |
| 2 | read descriptor |
| 3 | find |
| 4 | invalidate by address |
| 5 | invalidate all |

Top module: `seg_lookaside`

## Requirements
- R1: After reset every entry is invalid. Lookups miss, with hit 0, slot 0 and descriptor 0. A descriptor read of any in-range slot returns 0.
- R2: A valid 256 MB entry (size 00) hits when its tag equals address bits [63:28]. Hit, slot and descriptor appear on the lookup outputs one clock after the address is presented. When several entries match, the lowest slot wins. A miss gives hit 0, slot 0 and descriptor 0.
- R3: A write is rejected with `res_error` = 1 and leaves the table unchanged when any of these holds: the slot `op_rb[11:0]` is at or beyond DEPTH; any bit of `op_rb[26:12]` is set; size bit [63] is set; size 01 is requested with ALLOW_1T = 0; or the page-size code `op_rs[5:4]` is not enabled in PAGE_OK. An accepted write stores the tag, the valid bit and the descriptor, and they take effect at the next clock edge.
- R4: Read-tag (code 1) returns {tag, valid, 27 zero bits}, and read-descriptor (code 2) returns the stored descriptor. A slot at or beyond DEPTH gives `res_error` = 1 and data 0. Results appear one cycle after the request.
- R5: Find (code 3) returns the descriptor of the lowest matching entry, or all ones on a miss. When `op_mode64` = 0, the address is first reduced to its low 32 bits.
- R6: Invalidate-by-address (code 4) clears only the valid bit of the lowest matching valid entry. On a match it raises `flush_global` if `op_global` = 1, otherwise `flush_local`. With no match it raises neither.
- R7: Invalidate-all (code 5) with hints 0, 1, 2 or 6 clears every entry except slot 0. Hints 3 and 4 include slot 0.
- R8: Invalidate-all with hint 3 keeps entries whose class bit is 0. Hint 7 clears nothing. Hint 5 acts as hint 0 and pulses `hint_warn`. Every invalidate-all pulses `flush_local`.
- R9: A valid 1 TB entry (size 01) hits on any address whose bits [63:40] equal tag bits [35:12], independent of address bits [39:28], provided tag bits [11:0] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_ea | input | 64 | Lookup effective address |
| lk_hit | output | 1 | Registered lookup hit |
| lk_slot | output | $clog2(DEPTH) | Registered matching slot |
| lk_desc | output | 64 | Registered matching descriptor |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation code |
| op_rb | input | 64 | Address / slot / tag operand |
| op_rs | input | 64 | Descriptor operand for writes |
| op_hint | input | 3 | Invalidate-all hint |
| op_global | input | 1 | Invalidate-by-address flush scope |
| op_mode64 | input | 1 | 1 = 64-bit address mode for find |
| res_valid | output | 1 | Operation result strobe |
| res_data | output | 64 | Operation result data |
| res_error | output | 1 | Operation rejected |
| flush_local | output | 1 | Local flush request pulse |
| flush_global | output | 1 | Global flush request pulse |
| hint_warn | output | 1 | Undefined invalidate-all hint seen |

## Verification
The bench builds two instances.

The first has DEPTH = 32 and 1 TB segments enabled. It covers:
- the dual-granularity match and the lowest-slot priority;
- every invalidate-all hint class;
- rejection of slot 32, which lies just past the table.

The second has DEPTH = 64 and 1 TB segments disabled. It shows that slot 40 becomes writable and readable, that slot 64 is rejected, and that a 1 TB write is refused when the parameter turns the feature off.

// File: rtl/seg_lookaside.sv
module seg_lookaside #(
  parameter int DEPTH = 32,
  parameter bit ALLOW_1T = 1'b1,
  parameter logic [3:0] PAGE_OK = 4'b0111
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [63:0]              lk_ea,
  output logic                     lk_hit,
  output logic [$clog2(DEPTH)-1:0] lk_slot,
  output logic [63:0]              lk_desc,
  input  logic                     op_valid,
  input  logic [2:0]               op_code,
  input  logic [63:0]              op_rb,
  input  logic [63:0]              op_rs,
  input  logic [2:0]               op_hint,
  input  logic                     op_global,
  input  logic                     op_mode64,
  output logic                     res_valid,
  output logic [63:0]              res_data,
  output logic                     res_error,
  output logic                     flush_local,
  output logic                     flush_global,
  output logic                     hint_warn
);
  localparam int SW = $clog2(DEPTH);
  localparam logic [2:0] OP_WR = 3'd0, OP_RTAG = 3'd1, OP_RDSC = 3'd2,
                         OP_FIND = 3'd3, OP_INVA = 3'd4, OP_INVALL = 3'd5;

  logic [35:0]      tag_q [DEPTH];
  logic [63:0]      dsc_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  function automatic logic [SW:0] pick(input logic [DEPTH-1:0] v);
    logic [SW:0] r;
    r = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, SW'(i)};
    return r;
  endfunction

  logic [63:0] q_ea;
  assign q_ea = (op_code == OP_FIND && !op_mode64) ? {32'h0, op_rb[31:0]} : op_rb;

  logic [DEPTH-1:0] lk_m, op_m, clr;
  logic hint_clears, hint_all0;
  assign hint_clears = op_hint != 3'd7;
  assign hint_all0   = op_hint == 3'd3 || op_hint == 3'd4;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic s256, s1t;
    assign s256 = dsc_q[g][63:62] == 2'b00;
    assign s1t  = dsc_q[g][63:62] == 2'b01;
    assign lk_m[g] = vld_q[g] & ((s256 & (tag_q[g] == lk_ea[63:28])) |
                                 (s1t  & (tag_q[g] == {lk_ea[63:40], 12'h0})));
    assign op_m[g] = vld_q[g] & ((s256 & (tag_q[g] == q_ea[63:28])) |
                                 (s1t  & (tag_q[g] == {q_ea[63:40], 12'h0})));
    assign clr[g] = hint_clears & ((g != 0) | hint_all0) &
                    ~((op_hint == 3'd3) & ~dsc_q[g][7]);
  end

  logic [SW:0] lk_pick, op_pick;
  assign lk_pick = pick(lk_m);
  assign op_pick = pick(op_m);

  logic [11:0]   slot;
  logic [SW-1:0] si;
  logic          slot_ok, wr_bad;
  assign slot    = op_rb[11:0];
  assign si      = slot[SW-1:0];
  assign slot_ok = slot < 12'(DEPTH);
  assign wr_bad  = !slot_ok || (|op_rb[26:12]) || op_rs[63] ||
                   (op_rs[63:62] == 2'b01 && !ALLOW_1T) || !PAGE_OK[op_rs[5:4]];

  logic [63:0] n_data;
  logic        n_err, n_fl, n_fg, n_warn;
  always_comb begin
    n_data = '0;
    n_err  = 1'b0;
    n_fl   = 1'b0;
    n_fg   = 1'b0;
    n_warn = 1'b0;
    case (op_code)
      OP_WR:     n_err = wr_bad;
      OP_RTAG: begin
        n_err = !slot_ok;
        if (slot_ok) n_data = {tag_q[si], vld_q[si], 27'h0};
      end
      OP_RDSC: begin
        n_err = !slot_ok;
        if (slot_ok) n_data = dsc_q[si];
      end
      OP_FIND:   n_data = op_pick[SW] ? dsc_q[op_pick[SW-1:0]] : '1;
      OP_INVA: begin
        n_fl = op_pick[SW] & ~op_global;
        n_fg = op_pick[SW] & op_global;
      end
      OP_INVALL: begin
        n_fl   = 1'b1;
        n_warn = op_hint == 3'd5;
      end
      default:   n_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '0;
        dsc_q[i] <= '0;
      end
    end else if (op_valid) begin
      if (op_code == OP_WR && !wr_bad) begin
        tag_q[si] <= op_rb[63:28];
        vld_q[si] <= op_rb[27];
        dsc_q[si] <= op_rs;
      end else if (op_code == OP_INVA && op_pick[SW]) begin
        vld_q[op_pick[SW-1:0]] <= 1'b0;
      end else if (op_code == OP_INVALL) begin
        vld_q <= vld_q & ~clr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit       <= 1'b0;
      lk_slot      <= '0;
      lk_desc      <= '0;
      res_valid    <= 1'b0;
      res_data     <= '0;
      res_error    <= 1'b0;
      flush_local  <= 1'b0;
      flush_global <= 1'b0;
      hint_warn    <= 1'b0;
    end else begin
      lk_hit       <= lk_pick[SW];
      lk_slot      <= lk_pick[SW] ? lk_pick[SW-1:0] : '0;
      lk_desc      <= lk_pick[SW] ? dsc_q[lk_pick[SW-1:0]] : '0;
      res_valid    <= op_valid;
      res_data     <= op_valid ? n_data : '0;
      res_error    <= op_valid & n_err;
      flush_local  <= op_valid & n_fl;
      flush_global <= op_valid & n_fg;
      hint_warn    <= op_valid & n_warn;
    end
  end

  assert_err_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_error |-> res_valid);

  assert_read_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_error && $past(op_code == OP_RTAG || op_code == OP_RDSC))
      |-> $past(op_rb[11:0] < 12'(DEPTH)));

  assert_global_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_global |-> $past(op_valid && op_code == OP_INVA && op_global));

  assert_flush_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_local, flush_global}));

  assert_warn_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hint_warn |-> $past(op_valid && op_code == OP_INVALL && op_hint == 3'd5));
endmodule

// File: tb/seg_lookaside_test.sv
module seg_lookaside_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [63:0] lk_ea = '0;
  logic        lk_hit;
  logic [4:0]  lk_slot;
  logic [63:0] lk_desc;
  logic        op_valid = 1'b0, b_valid = 1'b0;
  logic [2:0]  op_code = '0, op_hint = '0;
  logic [63:0] op_rb = '0, op_rs = '0;
  logic        op_global = 1'b0, op_mode64 = 1'b1;
  logic        res_valid, res_error, flush_local, flush_global, hint_warn;
  logic [63:0] res_data;

  logic        b_hit, b_rv, b_err, b_fl, b_fg, b_warn;
  logic [5:0]  b_slot;
  logic [63:0] b_desc, b_data;

  seg_lookaside #(.DEPTH(32), .ALLOW_1T(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_slot(lk_slot),
    .lk_desc(lk_desc), .op_valid(op_valid), .op_code(op_code), .op_rb(op_rb),
    .op_rs(op_rs), .op_hint(op_hint), .op_global(op_global), .op_mode64(op_mode64),
    .res_valid(res_valid), .res_data(res_data), .res_error(res_error),
    .flush_local(flush_local), .flush_global(flush_global), .hint_warn(hint_warn));

  seg_lookaside #(.DEPTH(64), .ALLOW_1T(1'b0)) uut_b (
    .clk(clk), .rst_n(rst_n), .lk_ea(64'h0), .lk_hit(b_hit), .lk_slot(b_slot),
    .lk_desc(b_desc), .op_valid(b_valid), .op_code(op_code), .op_rb(op_rb),
    .op_rs(op_rs), .op_hint(op_hint), .op_global(op_global), .op_mode64(op_mode64),
    .res_valid(b_rv), .res_data(b_data), .res_error(b_err),
    .flush_local(b_fl), .flush_global(b_fg), .hint_warn(b_warn));

  localparam logic [2:0] WR = 3'd0, RTAG = 3'd1, RDSC = 3'd2, FIND = 3'd3,
                         INVA = 3'd4, INVALL = 3'd5;

  typedef struct {
    logic [63:0] data;
    logic [3:0]  flags;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic logic [63:0] mk_rb(logic [35:0] t, logic v, logic [11:0] s);
    return {t, v, 15'h0, s};
  endfunction

  task automatic do_op(logic [2:0] c, logic [63:0] rb, logic [63:0] rs, logic [2:0] h,
                       logic g, logic m64, logic [63:0] ed, logic [3:0] ef, string tag);
    exp_t e;
    e.data = ed;
    e.flags = ef;
    e.tag = tag;
    sb.push_back(e);
    op_code = c; op_rb = rb; op_rs = rs; op_hint = h; op_global = g; op_mode64 = m64;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (res_valid) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected result: got %h expected none", res_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (res_data !== e.data ||
            {res_error, flush_local, flush_global, hint_warn} !== e.flags) begin
          n_bad++;
          $display("FAIL %s: got data %h flags %b expected data %h flags %b", e.tag,
                   res_data, {res_error, flush_local, flush_global, hint_warn},
                   e.data, e.flags);
        end
      end
    end
  end

  task automatic look(logic [63:0] ea, logic eh, logic [4:0] es, logic [63:0] ed, string tag);
    lk_ea = ea;
    @(negedge clk);
    n_chk++;
    if ({lk_hit, lk_slot, lk_desc} !== {eh, es, ed}) begin
      n_bad++;
      $display("FAIL %s: got hit %b slot %0d desc %h expected hit %b slot %0d desc %h",
               tag, lk_hit, lk_slot, lk_desc, eh, es, ed);
    end
  endtask

  task automatic b_op(logic [2:0] c, logic [63:0] rb, logic [63:0] rs,
                      logic ee, logic [63:0] ed, string tag);
    op_code = c; op_rb = rb; op_rs = rs; op_hint = 3'd0; op_global = 1'b0; op_mode64 = 1'b1;
    b_valid = 1'b1;
    @(negedge clk);
    b_valid = 1'b0;
    n_chk++;
    if ({b_rv, b_err, b_data} !== {1'b1, ee, ed}) begin
      n_bad++;
      $display("FAIL %s: got valid %b err %b data %h expected valid 1 err %b data %h",
               tag, b_rv, b_err, b_data, ee, ed);
    end
  endtask

  localparam logic [35:0] TA = 36'h000000123, TB = 36'h000000456, TC = 36'h000000900,
                          TE = 36'h000000901, T32 = 36'h000000007;
  localparam logic [63:0] D0 = 64'h0000_5555_0000_0000, D1 = 64'h0000_6666_0000_0080,
                          D2 = 64'h0000_1111_0000_0000, D5 = 64'h4000_2222_0000_0090,
                          D7 = 64'h0000_7777_0000_0080, D9 = 64'h0000_3333_0000_0080,
                          D11 = 64'h0000_4444_0000_0000;
  localparam logic [63:0] RB1T = {24'h000ABC, 12'h000, 1'b1, 15'h0, 12'd5};
  localparam logic [63:0] EA1T = {24'h000ABC, 40'h12_3456_7890};
  localparam logic [63:0] EA32 = 64'h0000_0000_7000_0000;

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if ({res_valid, flush_local, flush_global, lk_hit} !== 4'b0) begin
      n_bad++;
      $display("FAIL R1 outputs in reset: got %b expected 0000",
               {res_valid, flush_local, flush_global, lk_hit});
    end
    rst_n = 1'b1;
    @(negedge clk);
    look(64'h0, 1'b0, 5'd0, 64'h0, "R1 lookup after reset");
    do_op(RDSC, 64'd4, 0, 0, 0, 1, 64'h0, 4'b0000, "R1 descriptor after reset");

    do_op(WR, mk_rb(TA, 1, 2), D2, 0, 0, 1, 0, 4'b0000, "R3 write slot 2");
    do_op(WR, RB1T, D5, 0, 0, 1, 0, 4'b0000, "R3 write 1T slot 5");
    do_op(WR, mk_rb(TA, 1, 7), D7, 0, 0, 1, 0, 4'b0000, "R3 write slot 7");
    do_op(WR, mk_rb(TB, 1, 9), D9, 0, 0, 1, 0, 4'b0000, "R3 write slot 9");
    do_op(WR, mk_rb(T32, 1, 11), D11, 0, 0, 1, 0, 4'b0000, "R3 write slot 11");
    do_op(WR, mk_rb(36'h111, 1, 32), D2, 0, 0, 1, 0, 4'b1000, "R3 slot beyond depth");
    do_op(WR, mk_rb(36'h111, 1, 3) | 64'h1000, D2, 0, 0, 1, 0, 4'b1000, "R3 reserved bit");
    do_op(WR, mk_rb(36'h111, 1, 3), 64'h8000_0000_0000_0000, 0, 0, 1, 0, 4'b1000,
          "R3 undefined size");
    do_op(WR, mk_rb(36'h111, 1, 3), 64'h30, 0, 0, 1, 0, 4'b1000, "R3 bad page code");
    do_op(RDSC, 64'd3, 0, 0, 0, 1, 64'h0, 4'b0000, "R3 rejected write left descriptor");
    do_op(RTAG, 64'd3, 0, 0, 0, 1, 64'h0, 4'b0000, "R3 rejected write left tag");

    look({TA, 28'h0ABCDEF}, 1'b1, 5'd2, D2, "R2 256M hit lowest slot");
    look({36'h000000124, 28'h0}, 1'b0, 5'd0, 64'h0, "R2 neighbour segment miss");
    look(EA1T, 1'b1, 5'd5, D5, "R9 1T hit ignoring bits 39:28");

    do_op(RTAG, 64'd2, 0, 0, 0, 1, {TA, 1'b1, 27'h0}, 4'b0000, "R4 read tag slot 2");
    do_op(RDSC, 64'd5, 0, 0, 0, 1, D5, 4'b0000, "R4 read descriptor slot 5");
    do_op(RTAG, 64'd40, 0, 0, 0, 1, 64'h0, 4'b1000, "R4 read out of range");

    do_op(FIND, {TA, 28'h0}, 0, 0, 0, 1, D2, 4'b0000, "R5 find hit");
    do_op(FIND, {36'h000000777, 28'h0}, 0, 0, 0, 1, '1, 4'b0000, "R5 find miss all ones");
    do_op(FIND, 64'hFFFF_FFFF_7000_0000, 0, 0, 0, 0, D11, 4'b0000, "R5 find 32-bit mode");
    do_op(FIND, 64'hFFFF_FFFF_7000_0000, 0, 0, 0, 1, '1, 4'b0000, "R5 find 64-bit mode");

    do_op(INVA, {TB, 28'h0}, 0, 0, 1, 1, 0, 4'b0010, "R6 invalidate global flush");
    look({TB, 28'h0}, 1'b0, 5'd0, 64'h0, "R6 invalidated entry misses");
    do_op(INVA, {TB, 28'h0}, 0, 0, 1, 1, 0, 4'b0000, "R6 no match no flush");
    do_op(INVA, {TA, 28'h0}, 0, 0, 0, 1, 0, 4'b0100, "R6 invalidate local flush");
    look({TA, 28'h0}, 1'b1, 5'd7, D7, "R6 only lowest match cleared");

    do_op(WR, mk_rb(TC, 1, 0), D0, 0, 0, 1, 0, 4'b0000, "R3 write slot 0");
    do_op(INVALL, 0, 0, 3'd7, 0, 1, 0, 4'b0100, "R8 hint 7 flush only");
    look({TA, 28'h0}, 1'b1, 5'd7, D7, "R8 hint 7 kept slot 7");
    do_op(INVALL, 0, 0, 3'd3, 0, 1, 0, 4'b0100, "R8 hint 3");
    look({TA, 28'h0}, 1'b0, 5'd0, 64'h0, "R8 hint 3 cleared class 1");
    look(EA1T, 1'b0, 5'd0, 64'h0, "R8 hint 3 cleared 1T class 1");
    look(EA32, 1'b1, 5'd11, D11, "R8 hint 3 kept class 0");
    look({TC, 28'h0}, 1'b1, 5'd0, D0, "R8 hint 3 kept slot 0 class 0");
    do_op(INVALL, 0, 0, 3'd5, 0, 1, 0, 4'b0101, "R8 hint 5 warns");
    look(EA32, 1'b0, 5'd0, 64'h0, "R8 hint 5 cleared slot 11");
    look({TC, 28'h0}, 1'b1, 5'd0, D0, "R8 hint 5 kept slot 0");
    do_op(INVALL, 0, 0, 3'd4, 0, 1, 0, 4'b0100, "R7 hint 4");
    look({TC, 28'h0}, 1'b0, 5'd0, 64'h0, "R7 hint 4 cleared slot 0");

    do_op(WR, mk_rb(TC, 1, 0), D0, 0, 0, 1, 0, 4'b0000, "R3 rewrite slot 0");
    do_op(WR, mk_rb(TE, 1, 1), D1, 0, 0, 1, 0, 4'b0000, "R3 write slot 1");
    do_op(INVALL, 0, 0, 3'd0, 0, 1, 0, 4'b0100, "R7 hint 0");
    look({TE, 28'h0}, 1'b0, 5'd0, 64'h0, "R7 hint 0 cleared slot 1");
    look({TC, 28'h0}, 1'b1, 5'd0, D0, "R7 hint 0 kept slot 0");

    b_op(WR, mk_rb(36'h55, 1, 40), 64'h0, 1'b0, 64'h0, "R3 deep table slot 40");
    b_op(RTAG, 64'd40, 64'h0, 1'b0, {36'h55, 1'b1, 27'h0}, "R4 deep table read slot 40");
    b_op(WR, mk_rb(36'h55, 1, 64), 64'h0, 1'b1, 64'h0, "R3 deep table slot 64");
    b_op(WR, {24'hABC, 12'h0, 1'b1, 15'h0, 12'd41}, 64'h4000_0000_0000_0000, 1'b1, 64'h0,
         "R3 1T refused when disabled");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule